// File: doc/BRIEF.md
# LIN Controller Command Sequencer

This block sits between the host-visible control fields of a LIN/UART controller and the lower engines that handle headers, responses and raw bytes. The host writes an enable bit and a 3-bit command field through two separate write strobes. The block turns the registered pair into one operating mode and drives the enables of the header, response and byte engines. It also drives the checksum, frame-timeout and length-forcing controls.

Frame tasks (header transmit, response receive, response transmit) run until the matching engine reports completion. The command field then falls back to the listen encoding by itself. If the host clears the two low command bits while a frame task runs, the task stops at once and a sticky abort flag is raised. The host clears that flag with a write-one-to-clear pulse.

All outputs are decoded from registered state. A host write therefore takes effect in the cycle right after the clock edge that captures it, with no wait states. The block has no data path and no stream interface, so every pin is a plain control or status level or a single-cycle strobe.

Top module: `lin_cmd_seq`

## Requirements
- R1: While the registered enable is 0, every engine enable, `crc_en`, `timeout_en`, `len_zero`, `duplex` and `busy` are 0, whatever the command field holds. Clearing the enable takes effect in the cycle after the write, and `ctl_cmd` keeps its value.
- R2: While enabled, command 3'b000 (listen) drives `hdr_rx_en`=1, `crc_en`=1 and `timeout_en`=1, with all other engine enables and `busy` at 0.
- R3: While enabled, command 3'b001 drives only `hdr_tx_en`, 3'b010 only `rsp_rx_en` and 3'b011 only `rsp_tx_en`. In each case `busy`, `crc_en` and `timeout_en` are 1.
- R4: When enabled with command 001, 010 or 011 and no command write in the same cycle, the matching strobe (`hdr_tx_done`, `rsp_rx_done` or `rsp_tx_done` respectively) returns `ctl_cmd` to 3'b000 on the next cycle. `task_done` is 1 for exactly that one cycle.
- R5: A completion strobe that does not match the running command, or that arrives while disabled, in listen or in byte mode, changes neither `ctl_cmd` nor `task_done`.
- R6: While enabled with command 001, 010 or 011, a command write whose low two bits are 00 sets `abort_flag` on the next cycle. In that same cycle the task's engine enable drops. Clearing the enable bit during a task does not set `abort_flag`.
- R7: `abort_flag` stays at 1 until a cycle with `abort_clr`=1 clears it. Writing a new command does not clear it. If a set and a clear land in the same cycle, the set wins.
- R8: While enabled with command bit 2 at 1 (byte mode), `crc_en`=0, `timeout_en`=0, `len_zero`=1, `busy`=0, and all header and response enables are 0.
- R9: The byte-mode encodings are as follows. 3'b100 gives `byte_rx_en`=1 and `byte_tx_en`=1 with `duplex`=0. 3'b101 gives receive only. 3'b110 gives transmit only. 3'b111 gives both enables with `duplex`=1.
- R10: A command write made while disabled is stored and visible on `ctl_cmd`, but starts no engine. A later enable write starts that command.
- R11: A command write has priority over a completion strobe in the same cycle: `ctl_cmd` takes the written value and `task_done` stays 0.
- R12: After reset, `ctl_enabled`=0, `ctl_cmd`=3'b000, `abort_flag`=0 and `task_done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_we | input | 1 | Write strobe for the enable bit |
| en_wd | input | 1 | Enable value to write |
| cmd_we | input | 1 | Write strobe for the command field |
| cmd_wd | input | 3 | Command value to write |
| abort_clr | input | 1 | Write-one-to-clear pulse for the abort flag |
| hdr_tx_done | input | 1 | Header transmit engine finished |
| rsp_rx_done | input | 1 | Response receive engine finished |
| rsp_tx_done | input | 1 | Response transmit engine finished |
| ctl_enabled | output | 1 | Registered enable bit |
| ctl_cmd | output | 3 | Registered command field |
| abort_flag | output | 1 | Sticky abort indication |
| task_done | output | 1 | One-cycle pulse when a frame task completes |
| busy | output | 1 | A frame task is running |
| hdr_rx_en | output | 1 | Header reception engine enable |
| hdr_tx_en | output | 1 | Header transmission engine enable |
| rsp_rx_en | output | 1 | Response reception engine enable |
| rsp_tx_en | output | 1 | Response transmission engine enable |
| byte_rx_en | output | 1 | Byte receiver enable |
| byte_tx_en | output | 1 | Byte transmitter enable |
| duplex | output | 1 | Byte mode runs full duplex |
| crc_en | output | 1 | Checksum handling enabled |
| timeout_en | output | 1 | Frame timeout enabled |
| len_zero | output | 1 | Force data-length fields to zero; length register read-only |

## Verification
The assertions check, on every cycle, the rules that follow from the present state and its inputs:
- the outputs stay quiet while disabled;
- header and response enables are mutually exclusive;
- the checksum and timeout are suppressed in byte mode;
- a matching strobe returns the field to listen;
- a host write wins over a strobe;
- a stray strobe leaves the command alone;
- the abort flag is set and holds.

Only the bench scenarios can show whole sequences. These include a command written while disabled that later starts, an abort followed by a re-arm that leaves the flag set, and a same-cycle set and clear. They also cover long random interleavings of writes and strobes compared against a reference model.

// File: rtl/lin_seq_pkg.sv
package lin_seq_pkg;
  localparam int CMD_W     = 3;
  localparam int LOW_W     = 2;
  localparam int NUM_TASKS = 3;

  typedef enum logic [CMD_W-1:0] {
    CMD_LISTEN  = 3'b000,
    CMD_HDR_TX  = 3'b001,
    CMD_RSP_RX  = 3'b010,
    CMD_RSP_TX  = 3'b011,
    CMD_BYTE    = 3'b100,
    CMD_BYTE_RX = 3'b101,
    CMD_BYTE_TX = 3'b110,
    CMD_BYTE_FD = 3'b111
  } cmd_e;

  typedef struct packed {
    logic busy;
    logic hdr_rx;
    logic hdr_tx;
    logic rsp_rx;
    logic rsp_tx;
    logic byte_rx;
    logic byte_tx;
    logic duplex;
    logic crc;
    logic tmo;
    logic len_zero;
  } eng_en_t;
endpackage

// File: rtl/lin_task_match.sv
module lin_task_match
  import lin_seq_pkg::*;
#(
  parameter int N = NUM_TASKS
) (
  input  logic             ena,
  input  logic [CMD_W-1:0] cmd,
  input  logic [N-1:0]     strobe,
  output logic             hit,
  output logic             running
);
  logic [N-1:0] match;

  // Task i is encoded as command value i+1 in the frame half of the map.
  for (genvar i = 0; i < N; i++) begin : g_task
    assign match[i] = (cmd == CMD_W'(i + 1)) && strobe[i];
  end

  assign hit     = ena && (|match);
  assign running = ena && !cmd[CMD_W-1] && (cmd[LOW_W-1:0] != '0);
endmodule

// File: rtl/lin_cmd_reg.sv
module lin_cmd_reg
  import lin_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             en_wd,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wd,
  input  logic             hit,
  output logic             ena_q,
  output logic [CMD_W-1:0] cmd_q,
  output logic             done_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ena_q  <= 1'b0;
      cmd_q  <= CMD_LISTEN;
      done_q <= 1'b0;
    end else begin
      if (en_we) ena_q <= en_wd;
      if (cmd_we) begin
        cmd_q  <= cmd_wd;
        done_q <= 1'b0;
      end else if (hit) begin
        cmd_q  <= CMD_LISTEN;
        done_q <= 1'b1;
      end else begin
        done_q <= 1'b0;
      end
    end
  end

  // R4
  done_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !cmd_we |=> (cmd_q == CMD_LISTEN) && done_q);

  // R11
  host_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we |=> (cmd_q == $past(cmd_wd)) && !done_q);

  // R10
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_we && !hit |=> $stable(cmd_q) && !done_q);
endmodule

// File: rtl/lin_abort_flag.sv
module lin_abort_flag
  import lin_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             running,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wd,
  input  logic             clr,
  output logic             abort_q
);
  logic set_now;
  assign set_now = running && cmd_we && (cmd_wd[LOW_W-1:0] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       abort_q <= 1'b0;
    else if (set_now) abort_q <= 1'b1;
    else if (clr)     abort_q <= 1'b0;
  end

  // R6
  abort_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running && cmd_we && (cmd_wd[LOW_W-1:0] == '0) |=> abort_q);

  // R7
  abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_q && !clr |=> abort_q);
endmodule

// File: rtl/lin_mode_decode.sv
module lin_mode_decode
  import lin_seq_pkg::*;
(
  input  logic             ena,
  input  logic [CMD_W-1:0] cmd,
  output eng_en_t          en
);
  logic [LOW_W-1:0] sub;
  assign sub = cmd[LOW_W-1:0];

  always_comb begin
    en = '0;
    if (ena) begin
      if (cmd[CMD_W-1]) begin
        en.byte_rx  = (sub != 2'b10);
        en.byte_tx  = (sub != 2'b01);
        en.duplex   = (sub == 2'b11);
        en.len_zero = 1'b1;
      end else begin
        en.crc = 1'b1;
        en.tmo = 1'b1;
        unique case (sub)
          2'b00:   en.hdr_rx = 1'b1;
          2'b01:   begin en.hdr_tx = 1'b1; en.busy = 1'b1; end
          2'b10:   begin en.rsp_rx = 1'b1; en.busy = 1'b1; end
          default: begin en.rsp_tx = 1'b1; en.busy = 1'b1; end
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_cmd_seq.sv
module lin_cmd_seq
  import lin_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_we,
  input  logic             en_wd,
  input  logic             cmd_we,
  input  logic [CMD_W-1:0] cmd_wd,
  input  logic             abort_clr,
  input  logic             hdr_tx_done,
  input  logic             rsp_rx_done,
  input  logic             rsp_tx_done,
  output logic             ctl_enabled,
  output logic [CMD_W-1:0] ctl_cmd,
  output logic             abort_flag,
  output logic             task_done,
  output logic             busy,
  output logic             hdr_rx_en,
  output logic             hdr_tx_en,
  output logic             rsp_rx_en,
  output logic             rsp_tx_en,
  output logic             byte_rx_en,
  output logic             byte_tx_en,
  output logic             duplex,
  output logic             crc_en,
  output logic             timeout_en,
  output logic             len_zero
);
  logic    hit;
  logic    running;
  eng_en_t en;

  lin_task_match #(.N(NUM_TASKS)) u_match (
    .ena     (ctl_enabled),
    .cmd     (ctl_cmd),
    .strobe  ({rsp_tx_done, rsp_rx_done, hdr_tx_done}),
    .hit     (hit),
    .running (running)
  );

  lin_cmd_reg u_reg (
    .clk    (clk),
    .rst_n  (rst_n),
    .en_we  (en_we),
    .en_wd  (en_wd),
    .cmd_we (cmd_we),
    .cmd_wd (cmd_wd),
    .hit    (hit),
    .ena_q  (ctl_enabled),
    .cmd_q  (ctl_cmd),
    .done_q (task_done)
  );

  lin_abort_flag u_abort (
    .clk     (clk),
    .rst_n   (rst_n),
    .running (running),
    .cmd_we  (cmd_we),
    .cmd_wd  (cmd_wd),
    .clr     (abort_clr),
    .abort_q (abort_flag)
  );

  lin_mode_decode u_dec (
    .ena (ctl_enabled),
    .cmd (ctl_cmd),
    .en  (en)
  );

  assign busy       = en.busy;
  assign hdr_rx_en  = en.hdr_rx;
  assign hdr_tx_en  = en.hdr_tx;
  assign rsp_rx_en  = en.rsp_rx;
  assign rsp_tx_en  = en.rsp_tx;
  assign byte_rx_en = en.byte_rx;
  assign byte_tx_en = en.byte_tx;
  assign duplex     = en.duplex;
  assign crc_en     = en.crc;
  assign timeout_en = en.tmo;
  assign len_zero   = en.len_zero;

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_enabled |-> !(busy || hdr_rx_en || hdr_tx_en || rsp_rx_en || rsp_tx_en ||
                       byte_rx_en || byte_tx_en || crc_en || timeout_en || len_zero));

  // R2
  listen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_enabled && (ctl_cmd == CMD_LISTEN) |-> hdr_rx_en && !busy);

  // R3
  frame_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_rx_en, hdr_tx_en, rsp_rx_en, rsp_tx_en}));

  // R8
  byte_plain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_enabled && ctl_cmd[CMD_W-1] |-> !crc_en && !timeout_en && len_zero && !busy);

  // R5
  stray_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_enabled && (ctl_cmd == CMD_RSP_RX) && !cmd_we && !rsp_rx_done
      |=> (ctl_cmd == CMD_RSP_RX) && !task_done);
endmodule

// File: tb/tb_lin_cmd_seq.sv
module tb_lin_cmd_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_we = 0, en_wd = 0, cmd_we = 0, abort_clr = 0;
  logic [2:0] cmd_wd = '0;
  logic hdr_tx_done = 0, rsp_rx_done = 0, rsp_tx_done = 0;
  logic ctl_enabled, abort_flag, task_done, busy, hdr_rx_en, hdr_tx_en;
  logic rsp_rx_en, rsp_tx_en, byte_rx_en, byte_tx_en, duplex, crc_en, timeout_en, len_zero;
  logic [2:0] ctl_cmd;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  logic m_ena = 0, m_abort = 0, m_done = 0;
  logic [2:0] m_cmd = '0;

  always #5 clk = ~clk;

  lin_cmd_seq dut (
    .clk(clk), .rst_n(rst_n), .en_we(en_we), .en_wd(en_wd), .cmd_we(cmd_we),
    .cmd_wd(cmd_wd), .abort_clr(abort_clr), .hdr_tx_done(hdr_tx_done),
    .rsp_rx_done(rsp_rx_done), .rsp_tx_done(rsp_tx_done), .ctl_enabled(ctl_enabled),
    .ctl_cmd(ctl_cmd), .abort_flag(abort_flag), .task_done(task_done), .busy(busy),
    .hdr_rx_en(hdr_rx_en), .hdr_tx_en(hdr_tx_en), .rsp_rx_en(rsp_rx_en),
    .rsp_tx_en(rsp_tx_en), .byte_rx_en(byte_rx_en), .byte_tx_en(byte_tx_en),
    .duplex(duplex), .crc_en(crc_en), .timeout_en(timeout_en), .len_zero(len_zero)
  );

  // {busy,hdr_rx,hdr_tx,rsp_rx,rsp_tx,byte_rx,byte_tx,duplex,crc,tmo,len_zero}
  function automatic logic [10:0] exp_en(input logic ena, input logic [2:0] c);
    if (!ena) return '0;                          // R1
    case (c)
      3'b000: return 11'b01000000110;             // R2
      3'b001: return 11'b10100000110;             // R3
      3'b010: return 11'b10010000110;
      3'b011: return 11'b10001000110;
      3'b100: return 11'b00000110001;             // R8, R9
      3'b101: return 11'b00000100001;
      3'b110: return 11'b00000010001;
      default: return 11'b00000111001;
    endcase
  endfunction

  function automatic string auto_tag(input logic ena, input logic [2:0] c);
    if (!ena) return "R1";
    if (c == 3'b000) return "R2";
    if (!c[2]) return "R3";
    return "R9";
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    logic [10:0] act;
    string t;
    act = {busy, hdr_rx_en, hdr_tx_en, rsp_rx_en, rsp_tx_en, byte_rx_en, byte_tx_en,
           duplex, crc_en, timeout_en, len_zero};
    t = (tag == "") ? auto_tag(m_ena, m_cmd) : tag;
    check(t, "enables", 32'(act), 32'(exp_en(m_ena, m_cmd)));
    check((tag == "") ? "R4" : tag, "cmd", 32'(ctl_cmd), 32'(m_cmd));
    check((tag == "") ? "R5" : tag, "task_done", 32'(task_done), 32'(m_done));
    check((tag == "") ? "R7" : tag, "abort", 32'(abort_flag), 32'(m_abort));
    check((tag == "") ? "R10" : tag, "enabled", 32'(ctl_enabled), 32'(m_ena));
  endtask

  // Inputs are set at a negedge before calling; one clock, then compare.
  task automatic step(input string tag);
    logic n_ena, n_abort, n_done, match, run;
    logic [2:0] n_cmd;
    match = m_ena && ((m_cmd == 3'd1 && hdr_tx_done) || (m_cmd == 3'd2 && rsp_rx_done) ||
                      (m_cmd == 3'd3 && rsp_tx_done));
    run = m_ena && (m_cmd inside {3'd1, 3'd2, 3'd3});
    n_ena = en_we ? en_wd : m_ena;
    n_cmd = cmd_we ? cmd_wd : (match ? 3'd0 : m_cmd);
    n_done = !cmd_we && match;
    n_abort = (run && cmd_we && cmd_wd[1:0] == 2'b00) ? 1'b1 : (abort_clr ? 1'b0 : m_abort);
    @(posedge clk);
    @(negedge clk);
    m_ena = n_ena; m_cmd = n_cmd; m_done = n_done; m_abort = n_abort;
    {en_we, en_wd, cmd_we, cmd_wd, abort_clr, hdr_tx_done, rsp_rx_done, rsp_tx_done} = '0;
    compare_all(tag);
  endtask

  task automatic wr_cmd(input logic [2:0] c, input string tag);
    cmd_we = 1; cmd_wd = c; step(tag);
  endtask

  task automatic wr_en(input logic e, input string tag);
    en_we = 1; en_wd = e; step(tag);
  endtask

  initial begin
    #(2_000_000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    compare_all("R12");                           // R12 reset state
    rst_n = 1;
    @(negedge clk);
    compare_all("R12");

    // R10: command held while disabled, starts on enable
    wr_cmd(3'b001, "R10");
    check("R10", "hdr_tx_en off", 32'(hdr_tx_en), 0);
    wr_en(1'b1, "R10");
    check("R10", "hdr_tx_en on", 32'(hdr_tx_en), 1);

    // R4: completion returns to listen, one-cycle done pulse
    hdr_tx_done = 1; step("R4");
    check("R4", "done pulse", 32'(task_done), 1);
    step("R4");
    check("R4", "done low", 32'(task_done), 0);

    // R5: stray strobe
    wr_cmd(3'b010, "R3");
    hdr_tx_done = 1; rsp_tx_done = 1; step("R5");
    check("R5", "cmd kept", 32'(ctl_cmd), 2);

    // R6: abort while response receive runs
    wr_cmd(3'b000, "R6");
    check("R6", "abort set", 32'(abort_flag), 1);
    check("R6", "rsp_rx dropped", 32'(rsp_rx_en), 0);

    // R7: re-arm keeps flag, clear works, set beats clear
    wr_cmd(3'b011, "R7");
    check("R7", "kept on rearm", 32'(abort_flag), 1);
    abort_clr = 1; step("R7");
    check("R7", "cleared", 32'(abort_flag), 0);
    cmd_we = 1; cmd_wd = 3'b100; abort_clr = 1; step("R7");
    check("R7", "set wins", 32'(abort_flag), 1);
    abort_clr = 1; step("R7");

    // R11: host write beats strobe
    wr_cmd(3'b011, "R3");
    cmd_we = 1; cmd_wd = 3'b010; rsp_tx_done = 1; step("R11");
    check("R11", "cmd written", 32'(ctl_cmd), 2);

    // R1: disable mid-task, no abort
    wr_en(1'b0, "R1");
    check("R1", "no abort", 32'(abort_flag), 0);
    rsp_rx_done = 1; step("R5");                 // strobe while disabled ignored
    wr_en(1'b1, "R1");

    // R8 / R9 byte modes
    for (int k = 4; k < 8; k++) begin
      wr_cmd(3'(k), "R9");
      check("R8", "len_zero", 32'(len_zero), 1);
    end
    wr_cmd(3'b000, "R2");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      en_we       = ($urandom % 16) == 0;
      en_wd       = ($urandom % 4) != 0;
      cmd_we      = ($urandom % 6) == 0;
      cmd_wd      = 3'($urandom % 8);
      abort_clr   = ($urandom % 10) == 0;
      hdr_tx_done = ($urandom % 5) == 0;
      rsp_rx_done = ($urandom % 5) == 0;
      rsp_tx_done = ($urandom % 5) == 0;
      step("");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule